// File: doc/BRIEF.md
# Three-Port Serial Field Store

This block holds a video field in a wide internal array of storage. It offers two serial read ports (A and B) and one serial write port (C). The array is never accessed one word at a time. Each access moves a whole block of 16 words of 12 bits, in a transfer cycle started by the row strobe `rs_i`. The two-bit `mode_i` selects what that transfer does: load the port A latch, load the port B latch, write the words collected at port C into the array, or run a refresh cycle.

Between transfers, each port streams one word per shift strobe. Each port has its own strobes, so the three ports run independently of each other. Each read port has two stages:

- a holding latch, which a transfer fills;
- a shift register, which feeds the output.

Because of this, the next block can be fetched while the current one is still being shifted out. The write port keeps a valid flag for each word. A short block therefore updates only the word positions it actually received.

All strobes are synchronous enables sampled on `clk_i`. A cycle in which a strobe is high acts as that strobe's rising edge. The block address is `row_i * COLS + col_i`.

Top module: `sam_field_store`

## Requirements
- R1: A transfer runs only in a cycle with `rs_i` high. `mode_i[0]` is the first mode bit and `mode_i[1]` the second. The codes are: 2'b00 loads the port A latch, 2'b01 loads the port B latch, 2'b10 writes port C into the array, 2'b11 refreshes. With `rs_i` low, mode and address inputs have no effect.
- R2: Loading a read-port latch does not change the word presented on that port's output.
- R3: A block-start pulse copies the latch into the shift register and presents word 0 after that clock edge.
- R4: Each shift pulse advances the output by one word. The shift after word 15 reloads the shift register from the latch and presents that latch's word 0, so blocks stream back to back.
- R5: Ports A and B load, start and shift independently of each other.
- R6: Each port C shift pulse stores `c_d_i` at the next word position, starting at 0. A write transfer stores the collected words into the addressed block and empties port C.
- R7: A write transfer after fewer than 16 port C words writes only those positions. All other words of the block keep their previous contents.
- R8: After a `c_term_i` pulse, and after 16 words have been collected, further port C shifts are ignored until the next write transfer.
- R9: A refresh cycle changes no stored word and no port latch, and ignores the external address. An internal row counter advances by one per refresh and wraps from ROWS-1 to 0.
- R10: With its output enable low, a read port drives high impedance. With it high, the port drives its current word.
- R11: After reset, both shift registers and latches hold zero at word position 0, and port C is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs_i | input | 1 | Row strobe; a transfer runs in a cycle where it is high |
| mode_i | input | 2 | Transfer mode, bit 0 first mode bit, bit 1 second |
| row_i | input | $clog2(ROWS) | Row of the block address |
| col_i | input | $clog2(COLS) | Column block of the block address |
| a_shift_i | input | 1 | Port A shift strobe |
| a_start_i | input | 1 | Port A block start |
| a_oe_i | input | 1 | Port A output enable |
| a_q_o | output | DW | Port A serial data |
| b_shift_i | input | 1 | Port B shift strobe |
| b_start_i | input | 1 | Port B block start |
| b_oe_i | input | 1 | Port B output enable |
| b_q_o | output | DW | Port B serial data |
| c_shift_i | input | 1 | Port C shift strobe |
| c_term_i | input | 1 | Port C write terminate |
| c_d_i | input | DW | Port C serial data |

## Verification
A transfer takes effect at the clock edge where `rs_i` is high. Its result can be observed only after a later start pulse, because the shift register is a separate stage. Start and shift pulses update the read pointer at their edge, and the selected word appears on the port in the same cycle after that edge. The output enable acts combinationally. The bench drives every strobe for one cycle from a falling edge, then samples the outputs at the next falling edge, exactly one register stage after the stimulus.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    MODE_RD_A    = 2'b00,
    MODE_RD_B    = 2'b01,
    MODE_WR_C    = 2'b10,
    MODE_REFRESH = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/sam_array.sv
module sam_array #(
  parameter int DW   = 12,
  parameter int BLK  = 16,
  parameter int NBLK = 32,
  localparam int BAW = $clog2(NBLK)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [BAW-1:0]          wblk_i,
  input  logic [BLK-1:0][DW-1:0]  wdata_i,
  input  logic [BLK-1:0]          wmask_i,
  input  logic [BAW-1:0]          rblk_i,
  output logic [BLK-1:0][DW-1:0]  rdata_o
);
  logic [BLK-1:0][DW-1:0] mem_q [NBLK];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int i = 0; i < BLK; i++) begin
        if (wmask_i[i]) mem_q[wblk_i][i] <= wdata_i[i];
      end
    end
  end

  assign rdata_o = mem_q[rblk_i];
endmodule

// File: rtl/sam_rd_port.sv
module sam_rd_port #(
  parameter int DW  = 12,
  parameter int BLK = 16,
  localparam int PW = $clog2(BLK)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [BLK-1:0][DW-1:0] blk_i,
  input  logic                   start_i,
  input  logic                   shift_i,
  output logic [DW-1:0]          word_o,
  output logic [PW-1:0]          ptr_o
);
  logic [BLK-1:0][DW-1:0] latch_q, sr_q;
  logic [PW-1:0]          ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      sr_q    <= '0;
      ptr_q   <= '0;
    end else begin
      if (load_i) latch_q <= blk_i;
      // start and block end both take the pre-load latch value
      if (start_i) begin
        sr_q  <= latch_q;
        ptr_q <= '0;
      end else if (shift_i) begin
        if (ptr_q == PW'(BLK-1)) begin
          sr_q  <= latch_q;
          ptr_q <= '0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign word_o = sr_q[ptr_q];
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/sam_wr_port.sv
module sam_wr_port #(
  parameter int DW    = 12,
  parameter int BLK   = 16,
  localparam int PW   = $clog2(BLK),
  localparam int CNTW = $clog2(BLK+1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic                   term_i,
  input  logic [DW-1:0]          d_i,
  input  logic                   commit_i,
  output logic [BLK-1:0][DW-1:0] data_o,
  output logic [BLK-1:0]         vld_o,
  output logic [CNTW-1:0]        cnt_o,
  output logic                   stop_o
);
  logic [BLK-1:0][DW-1:0] wbuf_q;
  logic [BLK-1:0]         vld_q;
  logic [CNTW-1:0]        cnt_q;
  logic                   stop_q;
  logic                   accept;

  assign accept = shift_i && !stop_q && (cnt_q != CNTW'(BLK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q <= '0;
      vld_q  <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (commit_i) begin
      vld_q  <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      if (accept) begin
        wbuf_q[cnt_q[PW-1:0]] <= d_i;
        vld_q[cnt_q[PW-1:0]]  <= 1'b1;
        cnt_q                 <= cnt_q + 1'b1;
      end
      if (term_i) stop_q <= 1'b1;
    end
  end

  assign data_o = wbuf_q;
  assign vld_o  = vld_q;
  assign cnt_o  = cnt_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/sam_field_store.sv
module sam_field_store
  import sam_pkg::*;
#(
  parameter int DW   = 12,
  parameter int BLK  = 16,
  parameter int ROWS = 8,
  parameter int COLS = 4,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int NBLK = ROWS * COLS,
  localparam int BAW  = $clog2(NBLK),
  localparam int PW   = $clog2(BLK),
  localparam int CNTW = $clog2(BLK+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rs_i,
  input  logic [1:0]    mode_i,
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  input  logic          a_shift_i,
  input  logic          a_start_i,
  input  logic          a_oe_i,
  output logic [DW-1:0] a_q_o,
  input  logic          b_shift_i,
  input  logic          b_start_i,
  input  logic          b_oe_i,
  output logic [DW-1:0] b_q_o,
  input  logic          c_shift_i,
  input  logic          c_term_i,
  input  logic [DW-1:0] c_d_i
);
  xfer_mode_e             mode;
  logic                   do_wr, do_ref;
  logic [1:0]             rd_load, rd_start, rd_shift;
  logic [BAW-1:0]         blk_addr;
  logic [BLK-1:0][DW-1:0] arr_rdata, wr_data;
  logic [BLK-1:0]         wr_vld;
  logic [CNTW-1:0]        wr_cnt;
  logic                   wr_stop;
  logic [DW-1:0]          rd_word [2];
  logic [PW-1:0]          rd_ptr [2];
  logic [RW-1:0]          ref_row_q;

  assign mode     = xfer_mode_e'(mode_i);
  assign do_wr    = rs_i && (mode == MODE_WR_C);
  assign do_ref   = rs_i && (mode == MODE_REFRESH);
  assign rd_load  = {rs_i && (mode == MODE_RD_B), rs_i && (mode == MODE_RD_A)};
  assign rd_start = {b_start_i, a_start_i};
  assign rd_shift = {b_shift_i, a_shift_i};
  assign blk_addr = BAW'(int'(row_i) * COLS + int'(col_i));

  sam_array #(.DW(DW), .BLK(BLK), .NBLK(NBLK)) u_array (
    .clk_i   (clk_i),
    .we_i    (do_wr),
    .wblk_i  (blk_addr),
    .wdata_i (wr_data),
    .wmask_i (wr_vld),
    .rblk_i  (blk_addr),
    .rdata_o (arr_rdata)
  );

  for (genvar p = 0; p < 2; p++) begin : g_rd
    sam_rd_port #(.DW(DW), .BLK(BLK)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (rd_load[p]),
      .blk_i   (arr_rdata),
      .start_i (rd_start[p]),
      .shift_i (rd_shift[p]),
      .word_o  (rd_word[p]),
      .ptr_o   (rd_ptr[p])
    );
  end

  sam_wr_port #(.DW(DW), .BLK(BLK)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (c_shift_i),
    .term_i   (c_term_i),
    .d_i      (c_d_i),
    .commit_i (do_wr),
    .data_o   (wr_data),
    .vld_o    (wr_vld),
    .cnt_o    (wr_cnt),
    .stop_o   (wr_stop)
  );

  // internal refresh row, external address unused on refresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_row_q <= '0;
    else if (do_ref) ref_row_q <= (ref_row_q == RW'(ROWS-1)) ? '0 : ref_row_q + 1'b1;
  end

  assign a_q_o = a_oe_i ? rd_word[0] : 'z;
  assign b_q_o = b_oe_i ? rd_word[1] : 'z;
endmodule

// File: rtl/sam_field_store_chk.sv
module sam_field_store_chk #(
  parameter int DW    = 12,
  parameter int BLK   = 16,
  parameter int ROWS  = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int PW   = $clog2(BLK),
  localparam int CNTW = $clog2(BLK+1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rs_i,
  input logic [1:0]      mode_i,
  input logic            a_shift_i,
  input logic            a_start_i,
  input logic [DW-1:0]   a_word_i,
  input logic [PW-1:0]   a_ptr_i,
  input logic [CNTW-1:0] c_cnt_i,
  input logic            c_stop_i,
  input logic [RW-1:0]   ref_row_i
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_shift_i && !a_start_i) |=> $stable(a_word_i));

  p_start_word0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_start_i |=> (a_ptr_i == '0));

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_shift_i && !a_start_i) |=>
      (a_ptr_i == (($past(a_ptr_i) == PW'(BLK-1)) ? '0 : $past(a_ptr_i) + 1'b1)));

  p_commit_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i && mode_i == 2'b10) |=> (c_cnt_i == '0));

  p_term_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_stop_i && !(rs_i && mode_i == 2'b10)) |=> $stable(c_cnt_i));

  p_cnt_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cnt_i == CNTW'(BLK) && !(rs_i && mode_i == 2'b10)) |=> (c_cnt_i == CNTW'(BLK)));

  p_refresh_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i && mode_i == 2'b11) |=>
      (ref_row_i == (($past(ref_row_i) == RW'(ROWS-1)) ? '0 : $past(ref_row_i) + 1'b1)));
endmodule

bind sam_field_store sam_field_store_chk #(.DW(DW), .BLK(BLK), .ROWS(ROWS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rs_i      (rs_i),
  .mode_i    (mode_i),
  .a_shift_i (a_shift_i),
  .a_start_i (a_start_i),
  .a_word_i  (rd_word[0]),
  .a_ptr_i   (rd_ptr[0]),
  .c_cnt_i   (wr_cnt),
  .c_stop_i  (wr_stop),
  .ref_row_i (ref_row_q)
);

// File: tb/sam_field_store_tb.sv
`timescale 1ns/1ps
module sam_field_store_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rs = 0, a_sh = 0, a_st = 0, a_oe = 1, b_sh = 0, b_st = 0, b_oe = 1;
  logic        c_sh = 0, c_term = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  row = 0;
  logic [1:0]  col = 0;
  logic [11:0] c_d = 0;
  wire  [11:0] a_q, b_q;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sam_field_store u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rs_i(rs), .mode_i(mode), .row_i(row), .col_i(col),
    .a_shift_i(a_sh), .a_start_i(a_st), .a_oe_i(a_oe), .a_q_o(a_q),
    .b_shift_i(b_sh), .b_start_i(b_st), .b_oe_i(b_oe), .b_q_o(b_q),
    .c_shift_i(c_sh), .c_term_i(c_term), .c_d_i(c_d)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] m, input int r, input int c);
    @(negedge clk); mode = m; row = 3'(r); col = 2'(c); rs = 1;
    @(negedge clk); rs = 0;
  endtask
  task automatic shift_c(input logic [11:0] d);
    @(negedge clk); c_d = d; c_sh = 1;
    @(negedge clk); c_sh = 0;
  endtask
  task automatic term_c();
    @(negedge clk); c_term = 1;
    @(negedge clk); c_term = 0;
  endtask
  task automatic start_a();
    @(negedge clk); a_st = 1;
    @(negedge clk); a_st = 0;
  endtask
  task automatic shift_a();
    @(negedge clk); a_sh = 1;
    @(negedge clk); a_sh = 0;
  endtask
  task automatic start_b();
    @(negedge clk); b_st = 1;
    @(negedge clk); b_st = 0;
  endtask
  task automatic shift_b();
    @(negedge clk); b_sh = 1;
    @(negedge clk); b_sh = 0;
  endtask
  task automatic write_blk(input int r, input int c, input logic [11:0] base, input int n);
    for (int i = 0; i < n; i++) shift_c(base + 12'(i));
    xfer(2'b10, r, c);
  endtask

  task automatic t_reset();
    check("R11 port A after reset", a_q, 12'h000);
    check("R11 port B after reset", b_q, 12'h000);
  endtask

  task automatic t_stream();
    write_blk(1, 2, 12'h100, 16);   // R6
    write_blk(2, 3, 12'h200, 16);
    xfer(2'b00, 1, 2);              // R1 load A
    check("R2 load leaves output", a_q, 12'h000);
    start_a();
    check("R3 word 0 after start", a_q, 12'h100);
    for (int i = 1; i < 16; i++) begin
      shift_a();
      check("R4 shift advance", a_q, 12'h100 + 12'(i));
    end
    xfer(2'b00, 2, 3);
    check("R2 load mid-block", a_q, 12'h10F);
    shift_a();
    check("R4 back-to-back reload", a_q, 12'h200);
    shift_a();
    check("R4 next block word 1", a_q, 12'h201);
  endtask

  task automatic t_port_b();
    xfer(2'b01, 1, 2);
    check("R5 A unaffected by B load", a_q, 12'h201);
    start_b();
    check("R5 B word 0", b_q, 12'h100);
    shift_b(); shift_b();
    check("R5 B word 2", b_q, 12'h102);
    check("R5 A unaffected by B shift", a_q, 12'h201);
  endtask

  task automatic t_partial();
    write_blk(1, 2, 12'h300, 5);
    xfer(2'b00, 1, 2);
    start_a();
    for (int i = 0; i < 16; i++) begin
      check("R7 partial write", a_q, (i < 5) ? 12'h300 + 12'(i) : 12'h100 + 12'(i));
      if (i < 15) shift_a();
    end
  endtask

  task automatic t_terminate();
    write_blk(3, 1, 12'h500, 16);
    for (int i = 0; i < 3; i++) shift_c(12'h400 + 12'(i));
    term_c();
    shift_c(12'h4F0); shift_c(12'h4F1);
    xfer(2'b10, 3, 1);
    xfer(2'b00, 3, 1);
    start_a();
    for (int i = 0; i < 16; i++) begin
      check("R8 terminate", a_q, (i < 3) ? 12'h400 + 12'(i) : 12'h500 + 12'(i));
      if (i < 15) shift_a();
    end
    write_blk(3, 0, 12'h600, 18);   // last two beyond a block
    write_blk(3, 0, 12'h7AA, 1);    // port C emptied by previous commit
    xfer(2'b00, 3, 0);
    start_a();
    check("R6 port C restarts at word 0", a_q, 12'h7AA);
    for (int i = 1; i < 16; i++) begin
      shift_a();
      check("R8 overflow ignored", a_q, 12'h600 + 12'(i));
    end
  endtask

  task automatic t_refresh();
    shift_c(12'h7BB);               // pending, must not be written
    for (int i = 0; i < 10; i++) xfer(2'b11, 3, 0);
    start_a();
    check("R9 latch kept over refresh", a_q, 12'h7AA);
    xfer(2'b00, 3, 0);
    start_a();
    check("R9 array kept over refresh", a_q, 12'h7AA);
  endtask

  task automatic t_oe();
    @(negedge clk); a_oe = 0; #1;
    checks++;
    if (a_q === 12'h7AA) begin
      fails++;
      $display("FAIL R10 disabled port drives %h expected high impedance", a_q);
    end
    @(negedge clk); a_oe = 1; #1;
    check("R10 enabled port drives", a_q, 12'h7AA);
  endtask

  task automatic t_no_strobe();
    @(negedge clk); mode = 2'b00; row = 3'd1; col = 2'd2;
    repeat (3) @(negedge clk);
    mode = 2'b10; row = 3'd3; col = 2'd0;
    repeat (3) @(negedge clk);
    start_a();
    check("R1 no load without strobe", a_q, 12'h7AA);
    xfer(2'b00, 3, 0);
    start_a();
    check("R1 no write without strobe", a_q, 12'h7AA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_port_b();
    t_partial();
    t_terminate();
    t_refresh();
    t_oe();
    t_no_strobe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule